// File: doc/BRIEF.md
# Cache Line Diff and Splice Unit

This unit supports a release-consistent, delayed write-update coherence scheme. When the local processor takes ownership of a shared 128-byte block, the clean contents of that block are captured into a small release buffer. Later the unit reads back the dirty version of the same block and compares it word by word against the snapshot. It then streams out a compact update that carries only the modified 64-bit words and a mask that gives their positions. Nothing is sent for a block whose words are all unchanged.

Diffing starts at two points. When the release buffer becomes full, its oldest entry is diffed and evicted. When a release is requested, every buffered entry is diffed in the order it was captured. A separate splice path accepts the same compact update format together with the current contents of a stored line. It writes the listed words into their positions and returns the merged line.

Top module: `line_diff_splice`

## Requirements
- R1: After reset, acq_ready is 1 and dout_valid, fetch_valid, mrg_valid and rel_busy are all 0.
- R2: A block is captured on a clock edge where acq_valid and acq_ready are both 1. acq_ready is 0 while DEPTH entries are held or while rel_busy is 1, and the buffer never holds more than DEPTH entries.
- R3: While fewer than DEPTH entries are held and no release is pending, no dirty line is requested (fetch_valid stays 0) and no update is emitted.
- R4: When the buffer becomes full, only the oldest entry is diffed, using a dirty-line request whose fetch_addr holds until fetch_ready accepts it. Afterwards acq_ready returns to 1.
- R5: Mask bit i is 1 exactly when bits [64i+63:64i] of the dirty line differ from the same bits of the captured clean line.
- R6: Each update begins with a header beat: bits [63:32] hold the block address, bits [31:16] are zero and bits [15:0] hold the mask. dout_last is 0 on the header.
- R7: After the header, one beat follows for each set mask bit, in ascending word index, carrying that dirty word. dout_last is 1 on the final beat only. No beat is sent for an unchanged word.
- R8: An entry whose mask is zero produces no output at all and is removed from the buffer.
- R9: A one-cycle rel_req drains every held entry in capture order. rel_busy is 1 from the cycle after the request until the buffer is empty.
- R10: While dout_valid is 1 and dout_ready is 0, dout_valid stays 1 and dout_data and dout_last hold their values.
- R11: A splice header (same layout as R6) with a nonzero mask, followed by one sp_valid beat per set bit in ascending index, gives a one-cycle mrg_valid after the final beat. mrg_line is sp_line (sampled with the header) with the listed words replaced, and mrg_addr is the header address. Idle cycles between beats are allowed.
- R12: A splice header with a zero mask gives mrg_valid in the next cycle, with mrg_line equal to sp_line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_valid | input | 1 | Ownership acquired; capture a clean block |
| acq_ready | output | 1 | Release buffer can take a block |
| acq_addr | input | 32 | Block address to capture |
| acq_line | input | 1024 | Clean contents of the block |
| rel_req | input | 1 | One-cycle release request |
| rel_busy | output | 1 | Release drain in progress |
| fetch_valid | output | 1 | Request for the dirty version of a block |
| fetch_ready | input | 1 | Dirty line is presented on fetch_line this cycle |
| fetch_addr | output | 32 | Address of the requested dirty block |
| fetch_line | input | 1024 | Dirty contents of the block |
| dout_valid | output | 1 | Update stream beat valid |
| dout_ready | input | 1 | Update stream consumer ready |
| dout_data | output | 64 | Header or modified word |
| dout_last | output | 1 | Final beat of an update |
| sp_valid | input | 1 | Splice stream beat valid |
| sp_data | input | 64 | Splice header or word |
| sp_line | input | 1024 | Existing line, sampled with the splice header |
| mrg_valid | output | 1 | Merged line valid (one cycle) |
| mrg_addr | output | 32 | Address from the splice header |
| mrg_line | output | 1024 | Line after merging |

## Verification
The checker assumes that the update consumer and the dirty-line source follow valid/ready rules. It also assumes that no block address is captured twice while it is still buffered, and that rel_req is not raised in a way that starves capture forever. The bench keeps to these limits by using a distinct address for every captured block. It answers each fetch with a dirty line computed from that address and a chosen mask, and it changes dout_ready and fetch_ready from a pseudo-random sequence at falling edges only. Splice stimulus always sends exactly as many word beats as the header mask has set bits.

// File: rtl/lds_pkg.sv
// Shared types for the line diff/splice unit.
// Assumes: nothing beyond the users importing it.
package lds_pkg;

    // Diff engine sequencing
    typedef enum logic [1:0] {
        DE_IDLE  = 2'd0,
        DE_FETCH = 2'd1,
        DE_HDR   = 2'd2,
        DE_WORD  = 2'd3
    } diff_state_e;

    // Splice engine sequencing
    typedef enum logic {
        SP_HDR  = 1'b0,
        SP_WORD = 1'b1
    } splice_state_e;

endpackage

// File: rtl/lds_store.sv
// Release buffer: FIFO of (block address, clean line) snapshots.
// Assumes: push is never asserted when full, pop never when empty.
// Head entry stays constant until it is popped.
module lds_store #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 1024,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [LINE_W-1:0] push_line,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [LINE_W-1:0] head_line,
    output logic [CNT_W-1:0]  count
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    // Snapshot storage, written at the tail
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            line_q[wr_ptr] <= push_line;
        end
    end

    assign head_addr = addr_q[rd_ptr];
    assign head_line = line_q[rd_ptr];

endmodule

// File: rtl/lds_diff.sv
// Diff engine: fetches the dirty version of the head entry, builds the
// per-word change mask and streams a header plus the changed words.
// Assumes: head_addr/head_line stay constant from start until done.
module lds_diff
    import lds_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 64,
    parameter int WORDS  = 16,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int RSV_W  = WORD_W - ADDR_W - WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [LINE_W-1:0] head_line,
    output logic              busy,
    output logic              done,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [LINE_W-1:0] fetch_line,
    output logic              dout_valid,
    input  logic              dout_ready,
    output logic [WORD_W-1:0] dout_data,
    output logic              dout_last
);

    diff_state_e       state;
    logic [WORDS-1:0]  mask_r;
    logic [WORDS-1:0]  rem_r;
    logic [LINE_W-1:0] dirty_r;
    logic [WORDS-1:0]  cmp_mask;
    logic [IDX_W-1:0]  idx;
    logic              one_left;

    // Per-word comparison of dirty against clean
    for (genvar g = 0; g < WORDS; g++) begin : g_cmp
        assign cmp_mask[g] = fetch_line[g*WORD_W +: WORD_W] != head_line[g*WORD_W +: WORD_W];
    end

    // Lowest remaining modified word index
    always_comb begin
        idx = '0;
        for (int i = WORDS - 1; i >= 0; i--)
            if (rem_r[i]) idx = IDX_W'(i);
    end

    assign one_left    = (rem_r & (rem_r - 1'b1)) == '0;
    assign busy        = state != DE_IDLE;
    assign fetch_valid = state == DE_FETCH;
    assign fetch_addr  = head_addr;
    assign dout_valid  = (state == DE_HDR) || (state == DE_WORD);
    assign dout_last   = (state == DE_WORD) && one_left;

    // Output beat selection: header or modified word
    always_comb begin
        if (state == DE_HDR)
            dout_data = {head_addr, {RSV_W{1'b0}}, mask_r};
        else
            dout_data = dirty_r[idx*WORD_W +: WORD_W];
    end

    // Entry retirement pulse
    assign done = ((state == DE_FETCH) && fetch_ready && (cmp_mask == '0)) ||
                  ((state == DE_WORD) && dout_ready && one_left);

    // Sequencing of fetch, header and word beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= DE_IDLE;
            mask_r  <= '0;
            rem_r   <= '0;
            dirty_r <= '0;
        end else begin
            case (state)
                DE_IDLE: if (start) state <= DE_FETCH;
                DE_FETCH: if (fetch_ready) begin
                    mask_r  <= cmp_mask;
                    rem_r   <= cmp_mask;
                    dirty_r <= fetch_line;
                    state   <= (cmp_mask == '0) ? DE_IDLE : DE_HDR;
                end
                DE_HDR: if (dout_ready) state <= DE_WORD;
                DE_WORD: if (dout_ready) begin
                    rem_r[idx] <= 1'b0;
                    if (one_left) state <= DE_IDLE;
                end
                default: state <= DE_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lds_splice.sv
// Splice engine: takes a header (address, mask) with the existing line,
// then one word per set mask bit in ascending order, and emits the merged line.
// Assumes: the sender supplies exactly popcount(mask) word beats.
module lds_splice
    import lds_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 64,
    parameter int WORDS  = 16,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_valid,
    input  logic [WORD_W-1:0] sp_data,
    input  logic [LINE_W-1:0] sp_line,
    output logic              mrg_valid,
    output logic [ADDR_W-1:0] mrg_addr,
    output logic [LINE_W-1:0] mrg_line
);

    splice_state_e     state;
    logic [ADDR_W-1:0] addr_r;
    logic [WORDS-1:0]  rem_r;
    logic [LINE_W-1:0] work_r;
    logic [LINE_W-1:0] work_nxt;
    logic [WORDS-1:0]  rem_nxt;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] hdr_addr;
    logic [WORDS-1:0]  hdr_mask;

    assign hdr_addr = sp_data[WORD_W-1 -: ADDR_W];
    assign hdr_mask = sp_data[WORDS-1:0];

    // Position of the word the current beat carries
    always_comb begin
        idx = '0;
        for (int i = WORDS - 1; i >= 0; i--)
            if (rem_r[i]) idx = IDX_W'(i);
    end

    // Line with the incoming word written in
    always_comb begin
        work_nxt = work_r;
        work_nxt[idx*WORD_W +: WORD_W] = sp_data;
        rem_nxt = rem_r;
        rem_nxt[idx] = 1'b0;
    end

    // Header capture, word merge and result pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SP_HDR;
            addr_r    <= '0;
            rem_r     <= '0;
            work_r    <= '0;
            mrg_valid <= 1'b0;
            mrg_addr  <= '0;
            mrg_line  <= '0;
        end else begin
            mrg_valid <= 1'b0;
            if (sp_valid) begin
                if (state == SP_HDR) begin
                    addr_r <= hdr_addr;
                    if (hdr_mask == '0) begin
                        mrg_valid <= 1'b1;
                        mrg_addr  <= hdr_addr;
                        mrg_line  <= sp_line;
                    end else begin
                        work_r <= sp_line;
                        rem_r  <= hdr_mask;
                        state  <= SP_WORD;
                    end
                end else begin
                    work_r <= work_nxt;
                    rem_r  <= rem_nxt;
                    if (rem_nxt == '0) begin
                        mrg_valid <= 1'b1;
                        mrg_addr  <= addr_r;
                        mrg_line  <= work_nxt;
                        state     <= SP_HDR;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/line_diff_splice.sv
// Top: release buffer, diff engine and splice engine.
// Diffs start when the buffer becomes full (oldest first) or while a
// release drain is pending. Assumes distinct addresses among held entries.
module line_diff_splice #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 64,
    parameter int WORDS  = 16,
    parameter int DEPTH  = 4,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_valid,
    output logic              acq_ready,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic [LINE_W-1:0] acq_line,
    input  logic              rel_req,
    output logic              rel_busy,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [LINE_W-1:0] fetch_line,
    output logic              dout_valid,
    input  logic              dout_ready,
    output logic [WORD_W-1:0] dout_data,
    output logic              dout_last,
    input  logic              sp_valid,
    input  logic [WORD_W-1:0] sp_data,
    input  logic [LINE_W-1:0] sp_line,
    output logic              mrg_valid,
    output logic [ADDR_W-1:0] mrg_addr,
    output logic [LINE_W-1:0] mrg_line
);

    logic [CNT_W-1:0]  occ;
    logic [ADDR_W-1:0] head_addr;
    logic [LINE_W-1:0] head_line;
    logic              drain_q;
    logic              eng_busy;
    logic              eng_done;
    logic              eng_start;
    logic              push;

    assign acq_ready = (occ != CNT_W'(DEPTH)) && !drain_q;
    assign push      = acq_valid && acq_ready;
    assign rel_busy  = drain_q;
    assign eng_start = !eng_busy && (occ != '0) && ((occ == CNT_W'(DEPTH)) || drain_q);

    // Release drain flag: set by request, cleared once buffer is empty
    always_ff @(posedge clk) begin
        if (!rst_n)
            drain_q <= 1'b0;
        else if (rel_req)
            drain_q <= 1'b1;
        else if (drain_q && (occ == '0) && !eng_busy)
            drain_q <= 1'b0;
    end

    lds_store #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (acq_addr),
        .push_line (acq_line),
        .pop       (eng_done),
        .head_addr (head_addr),
        .head_line (head_line),
        .count     (occ)
    );

    lds_diff #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) u_diff (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (eng_start),
        .head_addr   (head_addr),
        .head_line   (head_line),
        .busy        (eng_busy),
        .done        (eng_done),
        .fetch_valid (fetch_valid),
        .fetch_ready (fetch_ready),
        .fetch_addr  (fetch_addr),
        .fetch_line  (fetch_line),
        .dout_valid  (dout_valid),
        .dout_ready  (dout_ready),
        .dout_data   (dout_data),
        .dout_last   (dout_last)
    );

    lds_splice #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) u_splice (
        .clk       (clk),
        .rst_n     (rst_n),
        .sp_valid  (sp_valid),
        .sp_data   (sp_data),
        .sp_line   (sp_line),
        .mrg_valid (mrg_valid),
        .mrg_addr  (mrg_addr),
        .mrg_line  (mrg_line)
    );

endmodule

// File: rtl/lds_chk.sv
// Protocol and ordering checks for line_diff_splice, attached by bind.
// Assumes: inputs follow valid/ready rules described in the brief.
module lds_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 64,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_ready,
    input logic              rel_busy,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              dout_valid,
    input logic              dout_ready,
    input logic [WORD_W-1:0] dout_data,
    input logic              dout_last,
    input logic [CNT_W-1:0]  occ
);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid && !dout_ready |=> dout_valid && $stable(dout_data) && $stable(dout_last));

    // R4
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

    // R3
    fetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (rel_busy || occ == CNT_W'(DEPTH)));

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R2
    drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_busy |-> !acq_ready);

    // R6
    hdr_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> !dout_last);

    // R7
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> !fetch_valid);

    // R9
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rel_busy) |-> occ == '0 && !dout_valid);

endmodule

bind line_diff_splice lds_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_ready   (acq_ready),
    .rel_busy    (rel_busy),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_addr  (fetch_addr),
    .dout_valid  (dout_valid),
    .dout_ready  (dout_ready),
    .dout_data   (dout_data),
    .dout_last   (dout_last),
    .occ         (occ)
);

// File: tb/line_diff_splice_tb.sv
// Self-checking bench: capture/diff sweeps over many masks, and splice sweeps.
module line_diff_splice_tb;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 64;
    localparam int WORDS  = 16;
    localparam int DEPTH  = 4;
    localparam int LINE_W = WORD_W * WORDS;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int N_IDS  = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acq_valid = 1'b0;
    logic              acq_ready;
    logic [ADDR_W-1:0] acq_addr = '0;
    logic [LINE_W-1:0] acq_line = '0;
    logic              rel_req = 1'b0;
    logic              rel_busy;
    logic              fetch_valid;
    logic              fetch_ready = 1'b1;
    logic [ADDR_W-1:0] fetch_addr;
    logic [LINE_W-1:0] fetch_line;
    logic              dout_valid;
    logic              dout_ready = 1'b1;
    logic [WORD_W-1:0] dout_data;
    logic              dout_last;
    logic              sp_valid = 1'b0;
    logic [WORD_W-1:0] sp_data = '0;
    logic [LINE_W-1:0] sp_line = '0;
    logic              mrg_valid;
    logic [ADDR_W-1:0] mrg_addr;
    logic [LINE_W-1:0] mrg_line;

    int errors = 0;
    int checks = 0;
    int hdr_cnt = 0;
    int fetch_seen = 0;
    int acq_log [N_IDS];
    int acq_n = 0;
    int rd_pos = 0;

    always #10 clk = ~clk;

    line_diff_splice #(
        .ADDR_W (ADDR_W), .WORD_W (WORD_W), .WORDS (WORDS), .DEPTH (DEPTH)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .acq_valid (acq_valid), .acq_ready (acq_ready), .acq_addr (acq_addr), .acq_line (acq_line),
        .rel_req (rel_req), .rel_busy (rel_busy),
        .fetch_valid (fetch_valid), .fetch_ready (fetch_ready), .fetch_addr (fetch_addr), .fetch_line (fetch_line),
        .dout_valid (dout_valid), .dout_ready (dout_ready), .dout_data (dout_data), .dout_last (dout_last),
        .sp_valid (sp_valid), .sp_data (sp_data), .sp_line (sp_line),
        .mrg_valid (mrg_valid), .mrg_addr (mrg_addr), .mrg_line (mrg_line)
    );

    function automatic logic [WORD_W-1:0] clean_word(int id, int i);
        return 64'h9E37_79B9_7F4A_7C15 * 64'(id * 17 + i + 1);
    endfunction

    function automatic logic [WORDS-1:0] mask_of(int id);
        if (id < 16) return 16'(1) << id;
        if (id == 16 || id == 19) return '0;
        if (id == 17) return 16'hFFFF;
        if (id == 18) return 16'h8001;
        return 16'((id * 40503) ^ (id << 5));
    endfunction

    function automatic logic [WORD_W-1:0] dirty_word(int id, int i);
        logic [WORDS-1:0] m = mask_of(id);
        return m[i] ? clean_word(id, i) ^ (64'h1 << ((id + i) % 64)) : clean_word(id, i);
    endfunction

    function automatic logic [LINE_W-1:0] clean_line(int id);
        logic [LINE_W-1:0] l;
        for (int i = 0; i < WORDS; i++) l[i*WORD_W +: WORD_W] = clean_word(id, i);
        return l;
    endfunction

    function automatic logic [LINE_W-1:0] dirty_line(int id);
        logic [LINE_W-1:0] l;
        for (int i = 0; i < WORDS; i++) l[i*WORD_W +: WORD_W] = dirty_word(id, i);
        return l;
    endfunction

    function automatic int low_idx(logic [WORDS-1:0] m);
        for (int i = 0; i < WORDS; i++) if (m[i]) return i;
        return 0;
    endfunction

    // Dirty-line source modelled from the address
    assign fetch_line = dirty_line(int'((fetch_addr - BASE) >> 7));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Consumer and fetch responder with pseudo-random back-pressure
    logic [WORDS-1:0]  rx_rem = '0;
    int                rx_id = 0;
    logic              in_pkt = 1'b0;
    logic              prev_stall = 1'b0;
    logic [WORD_W-1:0] prev_data = '0;
    logic [15:0]       lfsr = 16'hACE1;
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dout_ready  = lfsr[0] | lfsr[1];
            fetch_ready = lfsr[2] | lfsr[3];
            if (fetch_valid) fetch_seen++;
            if (prev_stall)
                check(dout_valid && dout_data == prev_data, "R10 hold", dout_data, prev_data);
            prev_stall = dout_valid && !dout_ready;
            prev_data  = dout_data;
            if (dout_valid && dout_ready) begin
                if (!in_pkt) begin
                    rx_id = int'((dout_data[63:32] - BASE) >> 7);
                    while (rd_pos < acq_n && mask_of(acq_log[rd_pos]) == '0) rd_pos++;
                    check(rd_pos < acq_n && rx_id == acq_log[rd_pos], "R9 order/R8 skip",
                          64'(rx_id), 64'(rd_pos < acq_n ? acq_log[rd_pos] : -1));
                    rd_pos++;
                    check(dout_data[15:0] == mask_of(rx_id), "R5 mask", 64'(dout_data[15:0]), 64'(mask_of(rx_id)));
                    check(dout_data[31:16] == '0 && !dout_last, "R6 header", dout_data, 64'(dout_last));
                    rx_rem = mask_of(rx_id);
                    in_pkt = 1'b1;
                    hdr_cnt++;
                end else begin
                    check(dout_data == dirty_word(rx_id, low_idx(rx_rem)), "R7 word",
                          dout_data, dirty_word(rx_id, low_idx(rx_rem)));
                    check(dout_last == ((rx_rem & (rx_rem - 1'b1)) == '0), "R7 last",
                          64'(dout_last), 64'((rx_rem & (rx_rem - 1'b1)) == '0));
                    rx_rem[low_idx(rx_rem)] = 1'b0;
                    if (rx_rem == '0) in_pkt = 1'b0;
                end
            end
        end
    end

    task automatic acquire(input int id);
        @(negedge clk);
        acq_valid = 1'b1;
        acq_addr  = BASE + 32'(id * 128);
        acq_line  = clean_line(id);
        while (!acq_ready) @(negedge clk);
        acq_log[acq_n] = id;
        acq_n++;
        @(posedge clk);
        @(negedge clk);
        acq_valid = 1'b0;
    endtask

    task automatic release_and_wait();
        int n = 0;
        @(negedge clk);
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        check(rel_busy && !acq_ready, "R9/R2 busy on release", 64'({rel_busy, acq_ready}), 64'b10);
        while (rel_busy && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(!rel_busy, "R9 drain finishes", 64'(rel_busy), 64'(0));
    endtask

    task automatic splice(input int id, input logic [WORDS-1:0] m, input bit gaps);
        logic [LINE_W-1:0] base;
        logic [LINE_W-1:0] expv;
        logic [WORDS-1:0] rem;
        int bad;
        for (int i = 0; i < WORDS; i++) base[i*WORD_W +: WORD_W] = clean_word(id + 100, i);
        expv = base;
        @(negedge clk);
        sp_valid = 1'b1;
        sp_data  = {BASE + 32'(id * 128), 16'h0, m};
        sp_line  = base;
        rem = m;
        while (rem != '0) begin
            @(posedge clk);
            @(negedge clk);
            if (gaps) begin
                sp_valid = 1'b0;
                sp_line  = '1;
                @(posedge clk);
                @(negedge clk);
                sp_valid = 1'b1;
            end
            sp_data = ~clean_word(id + 200, low_idx(rem));
            expv[low_idx(rem)*WORD_W +: WORD_W] = ~clean_word(id + 200, low_idx(rem));
            rem[low_idx(rem)] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        sp_valid = 1'b0;
        bad = -1;
        for (int i = WORDS - 1; i >= 0; i--)
            if (mrg_line[i*WORD_W +: WORD_W] != expv[i*WORD_W +: WORD_W]) bad = i;
        if (m == '0)
            check(mrg_valid && bad < 0, "R12 zero-mask splice", 64'(bad), 64'(-1));
        else
            check(mrg_valid && bad < 0, "R11 merged line", 64'(bad), 64'(-1));
        check(mrg_addr == BASE + 32'(id * 128), "R11 merged addr", 64'(mrg_addr), 64'(BASE + 32'(id * 128)));
        @(negedge clk);
        check(!mrg_valid, "R11 single pulse", 64'(mrg_valid), 64'(0));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Main sequence
    initial begin
        int exp_hdrs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(acq_ready && !dout_valid && !fetch_valid && !mrg_valid && !rel_busy, "R1 reset state",
              64'({acq_ready, dout_valid, fetch_valid, mrg_valid, rel_busy}), 64'b10000);

        // R3: below full, nothing is diffed
        for (int id = 0; id < DEPTH - 1; id++) acquire(id);
        repeat (20) @(negedge clk);
        check(fetch_seen == 0 && hdr_cnt == 0, "R3 no diff below full", 64'(fetch_seen), 64'(0));

        // R4/R2: filling triggers one eviction of the oldest entry
        acquire(DEPTH - 1);
        check(!acq_ready, "R2 full blocks capture", 64'(acq_ready), 64'(0));
        repeat (60) @(negedge clk);
        check(hdr_cnt == 1, "R4 single eviction", 64'(hdr_cnt), 64'(1));
        check(acq_ready, "R4 space after eviction", 64'(acq_ready), 64'(1));

        release_and_wait();
        check(hdr_cnt == DEPTH, "R9 drain all", 64'(hdr_cnt), 64'(DEPTH));
        check(acq_ready, "R2 capture after drain", 64'(acq_ready), 64'(1));

        // Sweep of masks including zero, full and sparse
        for (int id = DEPTH; id < N_IDS; id++) acquire(id);
        release_and_wait();
        exp_hdrs = 0;
        for (int id = 0; id < N_IDS; id++) if (mask_of(id) != '0) exp_hdrs++;
        check(hdr_cnt == exp_hdrs, "R8 headers only for changed blocks", 64'(hdr_cnt), 64'(exp_hdrs));
        check(!in_pkt, "R7 last update complete", 64'(in_pkt), 64'(0));

        // Splice sweep
        splice(0, '0, 1'b0);
        for (int b = 0; b < WORDS; b++) splice(b + 1, 16'(1) << b, b[0]);
        splice(20, 16'hFFFF, 1'b0);
        splice(21, 16'h8001, 1'b1);
        for (int k = 0; k < 12; k++) splice(30 + k, 16'((k + 3) * 40503), k[0]);
        splice(50, '0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule